// File: doc/BRIEF.md
# Serial EEPROM Target Core with Page Buffer and Self-Timed Write

This block is the digital heart of a byte-wide serial memory that answers as a target on a two-wire I2C bus. Both bus lines are first synchronised and filtered in the system clock domain. From these filtered lines the block detects start and stop conditions and shifts bytes in and out. It acknowledges only when the device-select byte matches a fixed 4-bit family code followed by three strap inputs. This lets up to eight parts share one bus.

A host writes a two-byte word address and then one or more data bytes. These bytes gather in a 32-entry page buffer. A stop condition placed at a byte boundary copies the buffer into the array in one step. A busy interval of `WR_CYC` clocks then starts. For that whole interval the core ignores the bus, so the host can poll with the select byte until an ACK returns. The host reads with a select byte whose direction bit is 1. This read uses the current address counter, or an address loaded by a dummy write followed by a repeated start. Reading continues for as many bytes as the host acknowledges. A write-protect input locks the lowest quarter of the array. The array is a register array of `2**ADDR_W` bytes. Set `ADDR_W` to 13 for 8192 bytes; the default is 12.

Top module: `i2c_eeprom_core`

## Requirements
- R1: The core acknowledges a device-select byte only when its upper seven bits equal 1010 followed by strap[2:0]; bit 0 is the direction (1 = read). Any other select byte gets no ACK, and the core ignores the bus until the next start.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A level change on either line that lasts fewer than FILT clocks is ignored.
- R3: The core begins to pull SDA low only after it has seen SCL fall. It never begins to drive while SCL is high.
- R4: After an acknowledged write select, the next two bytes form the word address. The high byte comes first, and its low ADDR_W bits are used. Each data byte that follows is acknowledged.
- R5: During a write, the low 5 address bits advance after each data byte and wrap inside the 32-byte page. A later byte that lands on the same page slot replaces the earlier one.
- R6: A stop that ends a write with at least one data byte copies the page buffer into the array. It then starts a busy interval of WR_CYC clocks. During this interval no select byte is acknowledged and SDA stays released.
- R7: A stop that arrives part way through a data byte, or before any data byte, starts no busy interval and leaves the array unchanged. An address-only write still loads the address counter.
- R8: While wp is 1 at the stop, a write to a page whose two top address bits are 00 is dropped. Writes elsewhere are committed.
- R9: A read returns the byte at the address counter and then increments the counter by one, wrapping from 2**ADDR_W-1 to 0. This holds for current-address, random (dummy write plus repeated start) and sequential reads.
- R10: When the host answers a read byte with NACK, the core releases SDA and sends no further data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| strap | input | 3 | Device address straps |
| wp | input | 1 | Write protect for the lowest quarter of the array |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench targets a page write whose start offset and length push the address past the end of the page. A design that carried into the next page instead of wrapping would leave wrong bytes on both pages. It also issues stops after half a data byte and after an address-only write. A core that started a write cycle on either stop would refuse the next poll or corrupt a byte. Short SDA pulses while SCL is high check the filter: an unfiltered core would see a false start and stop and lose the write. Further cases are a sequential read across the top address, protected and unprotected writes under wp, select bytes with wrong straps, and polling during the busy interval.

// File: rtl/i2c_eeprom_core.sv
module i2c_eeprom_core #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  parameter int FILT   = 4,
  parameter int WR_CYC = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int FW    = $clog2(FILT + 1);
  localparam int CW    = $clog2(WR_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AH, S_AL, S_WR, S_RD} st_t;

  logic [1:0] s1, s2, flt, flt_d;
  logic [FW-1:0] fc [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt <= 2'b11; flt_d <= 2'b11;
      for (int i = 0; i < 2; i++) fc[i] <= '0;
    end else begin
      s1 <= {scl_i, sda_i};
      s2 <= s1;
      flt_d <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) fc[i] <= '0;
        else if (fc[i] == FW'(FILT - 1)) begin
          flt[i] <= s2[i];
          fc[i] <= '0;
        end else fc[i] <= fc[i] + 1'b1;
      end
    end
  end

  wire scl      = flt[1];
  wire sda      = flt[0];
  wire scl_rise = scl & ~flt_d[1];
  wire scl_fall = ~scl & flt_d[1];
  wire start_det = scl & flt_d[1] & ~sda & flt_d[0];
  wire stop_det  = scl & flt_d[1] & sda & ~flt_d[0];

  st_t st;
  logic [3:0] bitc;
  logic [7:0] shr, ahi;
  logic ack_ph, nack, have_data, busy;
  logic [ADDR_W-1:0] addr;
  logic [CW-1:0] wcnt;
  logic [PAGE-1:0] pval;
  logic [7:0] pbuf [PAGE];
  logic [7:0] mem [DEPTH];

  wire dev_hit  = shr[7:1] == {4'b1010, strap};
  wire lo_prot  = wp && (addr[ADDR_W-1 -: 2] == 2'b00);
  wire wr_go    = stop_det && !busy && st == S_WR && !ack_ph && bitc <= 4'd1 && have_data;
  wire byte_end = !busy && !start_det && !stop_det && scl_fall && !ack_ph && bitc == 4'd8;

  always_ff @(posedge clk) begin
    if (byte_end && st == S_WR) pbuf[addr[PAGE_W-1:0]] <= shr;
    if (wr_go && !lo_prot)
      for (int i = 0; i < PAGE; i++)
        if (pval[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitc <= '0; shr <= '0; ahi <= '0; ack_ph <= 1'b0;
      nack <= 1'b0; have_data <= 1'b0; busy <= 1'b0; addr <= '0;
      wcnt <= '0; pval <= '0; sda_oe <= 1'b0;
    end else if (busy) begin
      if (wcnt == CW'(WR_CYC - 1)) begin
        busy <= 1'b0;
        wcnt <= '0;
      end else wcnt <= wcnt + 1'b1;
    end else if (start_det) begin
      st <= S_DEV; bitc <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; bitc <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0;
      if (wr_go) begin
        busy <= 1'b1;
        wcnt <= '0;
      end
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (ack_ph) nack <= sda;
        else if (st == S_RD) bitc <= bitc + 1'b1;
        else if (bitc != 4'd8) begin
          shr <= {shr[6:0], sda};
          bitc <= bitc + 1'b1;
        end
      end
      if (scl_fall) begin
        if (ack_ph) begin
          ack_ph <= 1'b0; bitc <= '0; sda_oe <= 1'b0;
          if (st == S_RD) begin
            if (nack) st <= S_IDLE;
            else begin
              shr <= mem[addr];
              sda_oe <= ~mem[addr][7];
            end
          end
        end else if (bitc == 4'd8) begin
          ack_ph <= 1'b1;
          case (st)
            S_DEV: if (!dev_hit) begin
                     st <= S_IDLE;
                     ack_ph <= 1'b0;
                   end else begin
                     sda_oe <= 1'b1;
                     if (shr[0]) begin
                       st <= S_RD;
                       nack <= 1'b0;
                     end else st <= S_AH;
                   end
            S_AH: begin ahi <= shr; sda_oe <= 1'b1; st <= S_AL; end
            S_AL: begin
                    addr <= ADDR_W'({ahi, shr});
                    sda_oe <= 1'b1; st <= S_WR; pval <= '0; have_data <= 1'b0;
                  end
            S_WR: begin
                    sda_oe <= 1'b1; have_data <= 1'b1;
                    pval[addr[PAGE_W-1:0]] <= 1'b1;
                    addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                  end
            S_RD: begin sda_oe <= 1'b0; addr <= addr + 1'b1; end
            default: st <= S_IDLE;
          endcase
        end else if (st == S_RD) begin
          shr <= {shr[6:0], 1'b0};
          sda_oe <= ~shr[6];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk #(
  parameter int WR_CYC = 20000
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         scl_fall,
  input logic                         stop_det,
  input logic                         sda_oe,
  input logic                         busy,
  input logic [2:0]                   st,
  input logic [7:0]                   shr,
  input logic [2:0]                   strap,
  input logic [$clog2(WR_CYC+1)-1:0]  wcnt
);
  a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  a_r1_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(st) == 3'd1) |-> $past(shr[7:1]) == {4'b1010, $past(strap)});

  a_r6_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  a_r6_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  a_r6_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wcnt < ($clog2(WR_CYC+1))'(WR_CYC));

  a_r7_commit_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st) == 3'd4);
endmodule

bind i2c_eeprom_core i2c_eeprom_chk #(.WR_CYC(WR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .stop_det(stop_det),
  .sda_oe(sda_oe), .busy(busy), .st(st), .shr(shr), .strap(strap), .wcnt(wcnt)
);

// File: tb/test_i2c_eeprom_core.sv
module test_i2c_eeprom_core;
  localparam int AW = 12, DEPTH = 1 << AW, WRC = 1500, Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 0, rst_n = 0, scl = 1, m_sda = 1, wp = 0;
  wire sda_oe;
  wire sda_bus = m_sda & ~sda_oe;
  always #2 clk = ~clk;

  i2c_eeprom_core #(.ADDR_W(AW), .FILT(4), .WR_CYC(WRC)) i_i2c_eeprom_core (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap(STRAP), .wp(wp), .sda_oe(sda_oe));

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [DEPTH];
  bit known [DEPTH];
  logic [7:0] wdat [64];
  logic [AW-1:0] ptr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); m_sda = 1; wq(); scl = 1; wq(); m_sda = 0; wq(); scl = 0; wq(); endtask
  task automatic i2c_stop(); m_sda = 0; wq(); scl = 1; wq(); m_sda = 1; wq(); endtask
  task automatic wbit(input logic b); m_sda = b; wq(); scl = 1; wq(); wq(); scl = 0; wq(); endtask
  task automatic wbit_glitch();
    m_sda = 1; wq(); scl = 1; repeat (3) @(negedge clk);
    m_sda = 0; repeat (2) @(negedge clk); m_sda = 1; wq(); scl = 0; wq();
  endtask
  task automatic rbit(output logic b);
    m_sda = 1; wq(); scl = 1; wq(); b = sda_bus; wq(); scl = 0; wq();
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = !b;
  endtask
  task automatic rbyte(input logic nk, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(nk);
  endtask

  task automatic poll(output int n);
    logic a;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      i2c_start(); wbyte(DEVW, a); i2c_stop();
      if (a) break;
      n++;
    end
  endtask

  function automatic bit prot(input logic [AW-1:0] a, input logic w);
    return w && a[AW-1 -: 2] == 2'b00;
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input int len, input logic w);
    logic ack, all;
    int n;
    logic [AW-1:0] t;
    wp = w; all = 1;
    i2c_start();
    wbyte(DEVW, ack); all &= ack;
    wbyte(8'(16'(a) >> 8), ack); all &= ack;
    wbyte(8'(a), ack); all &= ack;
    for (int k = 0; k < len; k++) begin wbyte(wdat[k], ack); all &= ack; end
    i2c_stop();
    chk(all, "R4 address and data bytes acknowledged", int'(all), 1);
    for (int k = 0; k < len; k++) begin
      t = {a[AW-1:5], 5'(int'(a[4:0]) + k)};
      if (!prot(a, w)) begin mdl[t] = wdat[k]; known[t] = 1; end
    end
    ptr = {a[AW-1:5], 5'(int'(a[4:0]) + len)};
    poll(n);
    chk(n > 0, "R6 select NACKed during busy interval", n, 1);
    chk(n < 200, "R6 busy interval ends", n, 0);
    wp = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int len, input string req);
    logic ack;
    logic [7:0] d;
    logic [AW-1:0] t;
    i2c_start();
    wbyte(DEVW, ack); wbyte(8'(16'(a) >> 8), ack); wbyte(8'(a), ack);
    i2c_start();
    wbyte(DEVR, ack);
    chk(ack, "R9 read select acknowledged", int'(ack), 1);
    for (int k = 0; k < len; k++) begin
      t = AW'(int'(a) + k);
      rbyte(k == len - 1, d);
      if (known[t]) chk(d == mdl[t], req, int'(d), int'(mdl[t]));
    end
    i2c_stop();
    ptr = AW'(int'(a) + len);
  endtask

  task automatic cur_read(input string req);
    logic ack;
    logic [7:0] d;
    i2c_start(); wbyte(DEVR, ack); rbyte(1'b1, d); i2c_stop();
    chk(ack && d == mdl[ptr], req, int'(d), int'(mdl[ptr]));
    ptr = ptr + 1'b1;
  endtask

  initial begin
    logic ack, b;
    int n;
    logic [AW-1:0] ra;
    for (int i = 0; i < DEPTH; i++) begin known[i] = 0; mdl[i] = '0; end
    void'($urandom(32'd20250611));
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R6 SDA released in reset", int'(sda_oe), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R6 SDA released after reset", int'(sda_oe), 0);

    // R1 wrong straps and wrong family code
    i2c_start(); wbyte({4'b1010, ~STRAP, 1'b0}, ack); i2c_stop();
    chk(!ack, "R1 wrong strap not acknowledged", int'(ack), 0);
    i2c_start(); wbyte({4'b1110, STRAP, 1'b1}, ack); i2c_stop();
    chk(!ack, "R1 wrong family code not acknowledged", int'(ack), 0);

    // R3 ACK appears only after SCL falls
    i2c_start();
    for (int i = 7; i >= 1; i--) wbit(DEVW[i]);
    m_sda = DEVW[0]; wq(); scl = 1; wq(); wq();
    chk(sda_oe == 1'b0, "R3 no drive while SCL high", int'(sda_oe), 0);
    scl = 0; @(negedge clk);
    chk(sda_oe == 1'b0, "R3 no drive right at SCL fall", int'(sda_oe), 0);
    m_sda = 1; repeat (Q - 1) @(negedge clk);
    chk(sda_oe == 1'b1, "R3 ACK driven in SCL low phase", int'(sda_oe), 1);
    wq(); scl = 1; wq(); wq(); scl = 0; wq();
    i2c_stop();

    // R4 byte write
    wdat[0] = 8'hA5;
    do_write(12'h123, 1, 0);
    do_read(12'h123, 1, "R4 byte write read back");

    // R5 page write that wraps, read whole page sequentially
    for (int k = 0; k < 10; k++) wdat[k] = 8'(8'h40 + k);
    do_write(12'h21C, 10, 0);
    do_read(12'h200, 32, "R5 wrapped page write and R9 sequential read");

    // R5 overwrite within buffer
    for (int k = 0; k < 40; k++) wdat[k] = 8'(8'h80 + k);
    do_write(12'h245, 40, 0);
    do_read(12'h240, 32, "R5 later byte replaces earlier");

    // R8 protection
    wdat[0] = 8'h11; do_write(12'h010, 1, 0);
    wdat[0] = 8'h22; do_write(12'h500, 1, 0);
    wdat[0] = 8'hEE; do_write(12'h010, 1, 1);
    do_read(12'h010, 1, "R8 protected quarter unchanged");
    chk(mdl[12'h010] == 8'h11, "R8 model keeps old byte", int'(mdl[12'h010]), 8'h11);
    wdat[0] = 8'h77; do_write(12'h500, 1, 1);
    do_read(12'h500, 1, "R8 upper area writable with wp high");

    // R7 stop in the middle of a data byte
    wdat[0] = 8'h3C; do_write(12'h333, 1, 0);
    i2c_start(); wbyte(DEVW, ack); wbyte(8'h03, ack); wbyte(8'h33, ack);
    wbit(1); wbit(0); wbit(1); wbit(0);
    i2c_stop();
    poll(n);
    chk(n == 0, "R7 mid-byte stop starts no write cycle", n, 0);
    do_read(12'h333, 1, "R7 mid-byte stop leaves array unchanged");

    // R7 address-only write loads pointer
    i2c_start(); wbyte(DEVW, ack); wbyte(8'h05, ack); wbyte(8'h00, ack); i2c_stop();
    poll(n);
    chk(n == 0, "R7 address-only write starts no write cycle", n, 0);
    ptr = 12'h500;
    cur_read("R7 current read after address-only write");
    cur_read("R9 current read advances counter");

    // R2 glitches on SDA while SCL high are ignored
    i2c_start(); wbyte(DEVW, ack); wbyte(8'h07, ack); wbyte(8'h00, ack);
    for (int i = 0; i < 8; i++) wbit_glitch();
    rbit(b);
    chk(!b, "R2 data byte with glitches acknowledged", int'(b), 0);
    i2c_stop();
    mdl[12'h700] = 8'hFF; known[12'h700] = 1;
    poll(n);
    chk(n > 0, "R2 write cycle after glitched byte", n, 1);
    do_read(12'h700, 1, "R2 glitched byte stored intact");

    // R9 wrap from top of array
    wdat[0] = 8'h5A; do_write(12'hFFF, 1, 0);
    wdat[0] = 8'hC3; do_write(12'h000, 1, 0);
    do_read(12'hFFF, 2, "R9 sequential read wraps to address 0");
    cur_read("R9 counter after wrap");

    // R10 NACK ends read
    i2c_start(); wbyte(DEVW, ack); wbyte(8'h02, ack); wbyte(8'h00, ack);
    i2c_start(); wbyte(DEVR, ack);
    rbyte(1'b1, ra[7:0]);
    for (int i = 0; i < 8; i++) begin
      rbit(b);
      chk(b == 1'b1, "R10 SDA released after master NACK", int'(b), 1);
    end
    i2c_stop();

    // random mix
    for (int it = 0; it < 10; it++) begin
      int len;
      logic w;
      ra = AW'($urandom);
      len = 1 + int'($urandom % 16);
      w = 1'($urandom);
      for (int k = 0; k < len; k++) wdat[k] = 8'($urandom);
      do_write(ra, len, w);
      do_read(($urandom % 2 == 0) ? ra : {ra[AW-1:5], 5'd0}, 1 + int'($urandom % 6),
              "R9 random read matches model");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 195000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule